// File: doc/BRIEF.md
# Console Receive Register Block

This block sits between a serial receive front end and the processor's register bus on the console path. When the front end presents a strobe, it delivers either a decoded character or a line-break indication. The block captures that event in a 16-bit receive buffer, together with its error flags. It then sets a ready flag and, if the processor has enabled it, raises an interrupt request.

The processor reaches two registers through a one-bit address. A status register holds the ready flag and an interrupt-enable flag. The buffer register returns the character and the error flags. Reading the buffer consumes the character: the ready flag drops, the error flags are cleared and the interrupt request falls, while the character itself stays in place.

A break can also request a processor halt. This happens only when an external halt permission input is true at the time of the break. A seven-bit mode input forces the top bit of each received character to zero.

Top module: `con_rx_regs`

## Requirements
- R1: Reset leaves rdata at 0, irq at 0 and halt_req at 0. After reset, the status register and the buffer register both read 0.
- R2: The status register returns the ready flag in bit 7 and interrupt-enable in bit 6. All other bits read as zero. A status write changes only interrupt-enable, which is taken from wdata bit 6.
- R3: A received character is stored in buffer bits 7:0 with bits 15:8 zero, and the ready flag is set. On the clock edge that captures the character, irq rises if interrupt-enable is 1.
- R4: When seven_bit is 1, buffer bit 7 of the stored character is 0. All other character bits are kept.
- R5: A break loads the buffer with 16'hA400, which is the error summary bit 15, framing bit 13 and break bit 10, and sets the ready flag as a character does.
- R6: On the clock edge that captures a break, halt_req goes high for exactly one cycle, but only if halt_en is 1. Otherwise halt_req stays 0.
- R7: A buffer read returns all 16 buffer bits. It then clears the ready flag, clears buffer bits 15:8 while keeping bits 7:0, and drops irq.
- R8: A character that arrives while the ready flag is still set, with no buffer read in the same cycle, is stored with overrun bit 14 and error bit 15 also set.
- R9: A status write with bit 6 at 0 drops irq on that edge. A status write with bit 6 at 1 while the ready flag is set raises irq on that edge.
- R10: rdata changes only in the cycle after a read. A write to the buffer address has no effect on any register.
- R11: When a character arrives in the same cycle as a buffer read, the read returns the old value. The new character is then stored without overrun, and the ready flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a receive event is present |
| rx_break | input | 1 | When 1 with rx_valid, the event is a break |
| rx_char | input | 8 | Received character |
| seven_bit | input | 1 | Mask character bit 7 |
| halt_en | input | 1 | Permits a halt request on break |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects buffer |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The hardest case to reach is a character arriving in the same cycle as a buffer read. The read must return the old character, and the new one must not be marked as an overrun. The bench first leaves a character pending, then drives rx_valid together with the read strobe on one edge. Afterwards it reads the status and buffer registers to confirm that the ready flag is still set and the overrun bits are clear. Overrun itself is reached by sending two characters with no read between them.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;
  // Buffer register bit positions
  localparam int ERR_BIT  = 15;
  localparam int OVR_BIT  = 14;
  localparam int FRM_BIT  = 13;
  localparam int BRK_BIT  = 10;
  // Status register bit positions
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;

  typedef enum logic {
    ADDR_STAT = 1'b0,
    ADDR_BUF  = 1'b1
  } con_addr_e;
endpackage

// File: rtl/con_rx_buf.sv
module con_rx_buf
  import con_rx_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              seven_bit,
  input  logic              done_q,
  input  logic              buf_read,
  output logic [REG_W-1:0]  buf_q
);
  logic [CHAR_W-1:0] char_m;
  logic              overrun;
  logic [REG_W-1:0]  load_val;

  always_comb begin
    char_m = rx_char;
    if (seven_bit) char_m[CHAR_W-1] = 1'b0;
    // A read in the same cycle consumes the old character, so no overrun
    overrun = done_q & ~buf_read;
    load_val = '0;
    if (rx_break) begin
      load_val[ERR_BIT] = 1'b1;
      load_val[FRM_BIT] = 1'b1;
      load_val[BRK_BIT] = 1'b1;
    end else begin
      load_val[CHAR_W-1:0] = char_m;
    end
    if (overrun) begin
      load_val[ERR_BIT] = 1'b1;
      load_val[OVR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (rx_valid) begin
      buf_q <= load_val;
    end else if (buf_read) begin
      buf_q[REG_W-1:CHAR_W] <= '0;
    end
  end
endmodule

// File: rtl/con_rx_ctl.sv
module con_rx_ctl (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_break,
  input  logic halt_en,
  input  logic buf_read,
  input  logic stat_wr,
  input  logic wr_ie,
  output logic done_q,
  output logic ie_q,
  output logic irq,
  output logic halt_req
);
  logic done_n;
  logic ie_n;

  always_comb begin
    // A new arrival wins over a read-clear in the same cycle
    done_n = rx_valid | (done_q & ~buf_read);
    ie_n   = stat_wr ? wr_ie : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      ie_q     <= 1'b0;
      irq      <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      done_q   <= done_n;
      ie_q     <= ie_n;
      irq      <= done_n & ie_n;
      halt_req <= rx_valid & rx_break & halt_en;
    end
  end
endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
  import con_rx_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_break,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              seven_bit,
  input  logic              halt_en,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic              halt_req
);
  logic             buf_read;
  logic             stat_wr;
  logic             done_q;
  logic             ie_q;
  logic [REG_W-1:0] buf_q;
  logic [REG_W-1:0] stat_val;
  logic             wdata_unused;

  assign buf_read     = reg_rd & (reg_addr == ADDR_BUF);
  assign stat_wr      = reg_wr & (reg_addr == ADDR_STAT);
  assign wdata_unused = ^{wdata[REG_W-1:IE_BIT+1], wdata[IE_BIT-1:0]};

  always_comb begin
    stat_val           = '0;
    stat_val[DONE_BIT] = done_q;
    stat_val[IE_BIT]   = ie_q;
  end

  con_rx_buf #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rx_char   (rx_char),
    .seven_bit (seven_bit),
    .done_q    (done_q),
    .buf_read  (buf_read),
    .buf_q     (buf_q)
  );

  con_rx_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_break (rx_break),
    .halt_en  (halt_en),
    .buf_read (buf_read),
    .stat_wr  (stat_wr),
    .wr_ie    (wdata[IE_BIT]),
    .done_q   (done_q),
    .ie_q     (ie_q),
    .irq      (irq),
    .halt_req (halt_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (reg_rd) begin
      rdata <= (reg_addr == ADDR_BUF) ? buf_q : stat_val;
    end
  end
endmodule

// File: rtl/con_rx_regs_chk.sv
module con_rx_regs_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             halt_en,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             wr_ie,
  input logic [REG_W-1:0] rdata,
  input logic             irq,
  input logic             halt_req,
  input logic             done,
  input logic             ie
);
  p_done_on_rx_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> done);

  p_halt_cause_r6: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(rx_valid && rx_break && halt_en));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr && !rx_valid) |=> (!done && !irq));

  p_ie_off_drops_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr && !wr_ie) |=> !irq);

  p_irq_needs_ie_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ie && done));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(rdata));
endmodule

bind con_rx_regs con_rx_regs_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (rx_valid),
  .rx_break (rx_break),
  .halt_en  (halt_en),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .wr_ie    (wdata[con_rx_pkg::IE_BIT]),
  .rdata    (rdata),
  .irq      (irq),
  .halt_req (halt_req),
  .done     (done_q),
  .ie       (ie_q)
);

// File: tb/sim_con_rx_regs.sv
`timescale 1ns/1ps
module sim_con_rx_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_break = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        seven_bit = 1'b0;
  logic        halt_en = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic        halt_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  con_rx_regs u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_char(rx_char), .seven_bit(seven_bit), .halt_en(halt_en),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .halt_req(halt_req)
  );

  // {seven_bit, char, expected buffer}
  localparam logic [24:0] VECS [6] = '{
    {1'b0, 8'h41, 16'h0041},
    {1'b0, 8'hC3, 16'h00C3},
    {1'b1, 8'hC3, 16'h0043},
    {1'b1, 8'h7F, 16'h007F},
    {1'b0, 8'h00, 16'h0000},
    {1'b1, 8'hFF, 16'h007F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] c, input logic brk);
    rx_valid = 1'b1; rx_char = c; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = rdata;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 halt", {15'b0, halt_req}, 16'h0);
    rd(1'b0, v); chk("R1 status", v, 16'h0);
    rd(1'b1, v); chk("R1 buffer", v, 16'h0);

    // R3/R4 vector walk, interrupts disabled
    foreach (VECS[i]) begin
      seven_bit = VECS[i][24];
      rx_send(VECS[i][23:16], 1'b0);
      chk("R3 irq off", {15'b0, irq}, 16'h0);
      rd(1'b0, v); chk("R3 status done", v, 16'h0080);
      rd(1'b1, v); chk("R3/R4 buffer", v, VECS[i][15:0]);
      rd(1'b0, v); chk("R7 done cleared", v, 16'h0000);
    end
    seven_bit = 1'b0;

    // R2 only ie writable
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); chk("R2 status ie only", v, 16'h0040);
    chk("R2 irq idle", {15'b0, irq}, 16'h0);

    // R3 irq with ie set, R7 read drops it
    rx_send(8'h41, 1'b0);
    chk("R3 irq raised", {15'b0, irq}, 16'h1);
    rd(1'b1, v); chk("R7 buffer", v, 16'h0041);
    chk("R7 irq dropped", {15'b0, irq}, 16'h0);

    // R5/R6 break with halt permitted
    halt_en = 1'b1;
    rx_send(8'h00, 1'b1);
    chk("R6 halt pulse", {15'b0, halt_req}, 16'h1);
    @(negedge clk);
    chk("R6 halt one cycle", {15'b0, halt_req}, 16'h0);
    rd(1'b1, v); chk("R5 break pattern", v, 16'hA400);
    rd(1'b1, v); chk("R7 errors cleared", v, 16'h0000);

    // R6 break without permission
    halt_en = 1'b0;
    rx_send(8'h00, 1'b1);
    chk("R6 no halt", {15'b0, halt_req}, 16'h0);
    rd(1'b1, v); chk("R5 break again", v, 16'hA400);

    // R8 overrun
    wr(1'b0, 16'h0000);
    rx_send(8'h12, 1'b0);
    rx_send(8'h34, 1'b0);
    rd(1'b1, v); chk("R8 overrun", v, 16'hC034);
    rd(1'b1, v); chk("R7 char kept", v, 16'h0034);

    // R9 ie toggling
    rx_send(8'h55, 1'b0);
    chk("R9 irq off", {15'b0, irq}, 16'h0);
    wr(1'b0, 16'h0040);
    chk("R9 ie set raises", {15'b0, irq}, 16'h1);
    wr(1'b0, 16'h0000);
    chk("R9 ie clear drops", {15'b0, irq}, 16'h0);
    wr(1'b0, 16'h0040);
    chk("R9 ie set again", {15'b0, irq}, 16'h1);

    // R10 buffer write ignored, rdata held
    wr(1'b1, 16'hFFFF);
    rd(1'b0, v); chk("R10 status after buf write", v, 16'h00C0);
    held = rdata;
    repeat (3) @(negedge clk);
    chk("R10 rdata held", rdata, held);
    rd(1'b1, v); chk("R10 buffer unchanged", v, 16'h0055);
    chk("R7 irq dropped 2", {15'b0, irq}, 16'h0);

    // R11 arrival and read in same cycle
    wr(1'b0, 16'h0000);
    rx_send(8'h61, 1'b0);
    rx_valid = 1'b1; rx_char = 8'h62; reg_rd = 1'b1; reg_addr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; reg_rd = 1'b0;
    chk("R11 old value read", rdata, 16'h0061);
    rd(1'b0, v); chk("R11 done stays", v, 16'h0080);
    rd(1'b1, v); chk("R11 no overrun", v, 16'h0062);

    // R1 reset mid-operation
    rx_send(8'h77, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(1'b0, v); chk("R1 status after reset", v, 16'h0000);
    rd(1'b1, v); chk("R1 buffer after reset", v, 16'h0000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule